// File: doc/BRIEF.md
# Inset Window and Border Overlay

This block runs in the pixel clock domain of the main picture. It follows the main channel's horizontal and vertical sync pulses with its own pixel and line counters. From these counters it decides, pixel by pixel, whether the current pixel lies in a reduced inset picture, in a border drawn around that inset, or in the plain main picture.

It drives a select output that steers an external mixer to the inset. During border pixels it also supplies a border brightness level and a colour tag. While the active inset area is on screen, it issues one read per pixel to the inset picture memory, with a running address.

The number of lines per field is never programmed. The block measures it from one vertical sync to the next, and the line length from one horizontal sync to the next, so 625-line and 525-line sources both work. All configuration is sampled only at the vertical sync edge.

The per-pixel decision is a three-state machine over the regions OUTSIDE, BORDER and INSET. Each state's outputs are registered one pixel behind the counters.

Its transitions are:
- ENTER_FRAME: OUTSIDE to BORDER.
- ENTER_PICTURE: BORDER to INSET.
- ENTER_DIRECT: OUTSIDE to INSET, taken when the border is disabled.
- LEAVE_PICTURE: INSET to BORDER.
- LEAVE_FRAME: BORDER to OUTSIDE.
- LEAVE_DIRECT: INSET to OUTSIDE.
- HOLD: no change of region.

Top module: `pip_inset_overlay`

## Requirements
- R1: Size select. With `cfg_quarter`=0 the active inset is floor(L/3) pixels by floor(N/3) lines. With `cfg_quarter`=1 it is floor(L/4) by floor(N/4). L is the measured line length and N is the measured line count.
- R2: Corner select. `cfg_corner` bit 0 set places the inset at the right edge, clear at the left. Bit 1 set places it at the bottom, clear at the top. The outer edge of the border (or of the inset, when the border is off) lies 16 pixels from the chosen side edge and 8 lines from the chosen top or bottom edge.
- R3: Border geometry. With `cfg_frame_on`=1 a border surrounds the active inset on all four sides, outside it. The border is 2 pixels by 1 line when `cfg_frame_wide`=0, and 4 pixels by 2 lines when it is 1. With `cfg_frame_on`=0 there is no border, and `frame_px` stays low.
- R4: Border appearance. While `frame_px` is high, `frame_luma` and `frame_hue` carry the latched 4-bit brightness and 2-bit colour tag. Otherwise both are zero.
- R5: Select output. `sel` is high for every pixel inside the inset rectangle, border included, and low elsewhere.
- R6: Sync lock. A rising edge of `hsync` makes the next pixel index 0. A rising edge of `vsync`, which coincides with an `hsync` rise, makes the next line index 0. Every output reflects pixel index p one clock after the counter holds p.
- R7: Measurement. The line count used in a field is the number of `hsync` rises in the previous field. The line length is the number of clocks from the previous `hsync` rise to the one that coincides with the `vsync` rise.
- R8: Configuration is sampled only at the clock of a `vsync` rising edge. Changes at any other time have no effect on the outputs of the current field.
- R9: Memory read. `rd_en` is high exactly on active inset pixels. `rd_addr` is 0 at the inset's top-left pixel and advances by one for each following active inset pixel of the field, in raster order.
- R10: Reset state. While `rst_n` is low, and until the window has first been computed, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main-picture pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync | input | 1 | Main-channel horizontal sync, active high |
| vsync | input | 1 | Main-channel vertical sync, active high |
| cfg_quarter | input | 1 | 0: one third per dimension; 1: one quarter |
| cfg_corner | input | 2 | Bit 0 right, bit 1 bottom |
| cfg_frame_on | input | 1 | Border enable |
| cfg_frame_wide | input | 1 | Border width: 0 narrow, 1 wide |
| cfg_frame_luma | input | 4 | Border brightness level |
| cfg_frame_hue | input | 2 | Border colour tag |
| sel | output | 1 | Mixer select: inset or border pixel |
| frame_px | output | 1 | Current pixel is a border pixel |
| frame_luma | output | 4 | Border brightness, zero off border |
| frame_hue | output | 2 | Border colour tag, zero off border |
| rd_en | output | 1 | Inset memory read enable |
| rd_addr | output | PIX_W+LINE_W-3 | Inset memory read address |

## Verification
The configuration capture and the line-count capture happen on the same clock, because every field starts with a `vsync` rise that coincides with the `hsync` rise restarting line and pixel counting. The bench drives both on that clock in every field. It alternates between a 40-line and a 34-line field, and it writes an inverted configuration halfway through each field. Every pixel is judged against geometry computed arithmetically from the previous field's line count and the configuration present at the field edge. A block that applies the mid-field write, or that measures the current field rather than the previous one, therefore mismatches at the border and inset edges.

// File: rtl/pip_ovl_pkg.sv
package pip_ovl_pkg;

    localparam int LUMA_W = 4;
    localparam int HUE_W  = 2;

    typedef enum logic [1:0] {
        RG_OUTSIDE = 2'd0,
        RG_BORDER  = 2'd1,
        RG_INSET   = 2'd2
    } region_e;

    typedef struct packed {
        logic              quarter;
        logic [1:0]        corner;
        logic              frame_on;
        logic              frame_wide;
        logic [LUMA_W-1:0] luma;
        logic [HUE_W-1:0]  hue;
    } ovl_cfg_t;

endpackage

// File: rtl/pip_ovl_sync.sv
module pip_ovl_sync #(
    parameter int PIX_W  = 11,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs,
    input  logic              vs,
    output logic              hs_rise,
    output logic              vs_rise,
    output logic [PIX_W-1:0]  px,
    output logic [LINE_W-1:0] ln
);

    logic hs_q;
    logic vs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
        end else begin
            hs_q <= hs;
            vs_q <= vs;
        end
    end

    assign hs_rise = hs & ~hs_q;
    assign vs_rise = vs & ~vs_q;

    // pixel counter: restarts on each line start, saturates on a lost sync
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            px <= '0;
        end else if (hs_rise) begin
            px <= '0;
        end else if (px != {PIX_W{1'b1}}) begin
            px <= px + PIX_W'(1);
        end
    end

    // line counter: restarts on each field start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln <= '0;
        end else if (vs_rise) begin
            ln <= '0;
        end else if (hs_rise && (ln != {LINE_W{1'b1}})) begin
            ln <= ln + LINE_W'(1);
        end
    end

    AST_PX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        hs_rise |=> (px == '0));                                     // R6
    AST_LN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise |=> (ln == '0));                                     // R6

endmodule

// File: rtl/pip_ovl_geom.sv
module pip_ovl_geom
    import pip_ovl_pkg::*;
#(
    parameter int PIX_W     = 11,
    parameter int LINE_W    = 10,
    parameter int H_MARGIN  = 16,
    parameter int V_MARGIN  = 8,
    parameter int BH_NARROW = 2,
    parameter int BH_WIDE   = 4,
    parameter int BV_NARROW = 1,
    parameter int BV_WIDE   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vs_rise,
    input  logic [PIX_W-1:0]  px,
    input  logic [LINE_W-1:0] ln,
    input  ovl_cfg_t          cfg_in,
    output logic [LUMA_W-1:0] luma_q,
    output logic [HUE_W-1:0]  hue_q,
    output logic [PIX_W-1:0]  ox0,
    output logic [PIX_W-1:0]  ox1,
    output logic [PIX_W-1:0]  ix0,
    output logic [PIX_W-1:0]  ix1,
    output logic [LINE_W-1:0] oy0,
    output logic [LINE_W-1:0] oy1,
    output logic [LINE_W-1:0] iy0,
    output logic [LINE_W-1:0] iy1
);

    ovl_cfg_t          cfg_q;
    logic [PIX_W-1:0]  len_q;
    logic [LINE_W-1:0] lines_q;
    logic              upd;

    // field-start capture: configuration, last line length, last field line count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            len_q   <= '0;
            lines_q <= '0;
            upd     <= 1'b0;
        end else begin
            upd <= vs_rise;
            if (vs_rise) begin
                cfg_q   <= cfg_in;
                len_q   <= px + PIX_W'(1);
                lines_q <= ln + LINE_W'(1);
            end
        end
    end

    assign luma_q = cfg_q.luma;
    assign hue_q  = cfg_q.hue;

    logic [PIX_W-1:0]  w, bh, ow, ox0_n;
    logic [LINE_W-1:0] h, bv, oh, oy0_n;

    always_comb begin
        w  = cfg_q.quarter ? (len_q >> 2)   : (len_q / PIX_W'(3));
        h  = cfg_q.quarter ? (lines_q >> 2) : (lines_q / LINE_W'(3));
        bh = '0;
        bv = '0;
        if (cfg_q.frame_on) begin
            bh = cfg_q.frame_wide ? PIX_W'(BH_WIDE)  : PIX_W'(BH_NARROW);
            bv = cfg_q.frame_wide ? LINE_W'(BV_WIDE) : LINE_W'(BV_NARROW);
        end
        ow    = w + bh + bh;
        oh    = h + bv + bv;
        ox0_n = cfg_q.corner[0] ? (len_q - PIX_W'(H_MARGIN) - ow)
                                : PIX_W'(H_MARGIN);
        oy0_n = cfg_q.corner[1] ? (lines_q - LINE_W'(V_MARGIN) - oh)
                                : LINE_W'(V_MARGIN);
    end

    // window registered one cycle after the capture; empty until first field
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ox0 <= '0; ox1 <= '0; ix0 <= '0; ix1 <= '0;
            oy0 <= '0; oy1 <= '0; iy0 <= '0; iy1 <= '0;
        end else if (upd) begin
            ox0 <= ox0_n;
            ox1 <= ox0_n + ow;
            ix0 <= ox0_n + bh;
            ix1 <= ox0_n + bh + w;
            oy0 <= oy0_n;
            oy1 <= oy0_n + oh;
            iy0 <= oy0_n + bv;
            iy1 <= oy0_n + bv + h;
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_rise |=> $stable(cfg_q));                                // R8
    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(ix0) && $stable(iy0) && $stable(ox1)));    // R8

endmodule

// File: rtl/pip_ovl_fsm.sv
module pip_ovl_fsm
    import pip_ovl_pkg::*;
#(
    parameter int PIX_W  = 11,
    parameter int LINE_W = 10,
    parameter int ADDR_W = PIX_W + LINE_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  px,
    input  logic [LINE_W-1:0] ln,
    input  logic [PIX_W-1:0]  ox0,
    input  logic [PIX_W-1:0]  ox1,
    input  logic [PIX_W-1:0]  ix0,
    input  logic [PIX_W-1:0]  ix1,
    input  logic [LINE_W-1:0] oy0,
    input  logic [LINE_W-1:0] oy1,
    input  logic [LINE_W-1:0] iy0,
    input  logic [LINE_W-1:0] iy1,
    input  logic [LUMA_W-1:0] luma_q,
    input  logic [HUE_W-1:0]  hue_q,
    output logic              sel,
    output logic              frame_px,
    output logic [LUMA_W-1:0] frame_luma,
    output logic [HUE_W-1:0]  frame_hue,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr
);

    region_e state, nxt;
    logic    in_outer, in_inner, top_left;
    logic [ADDR_W-1:0] cnt;

    assign in_outer = (px >= ox0) && (px < ox1) && (ln >= oy0) && (ln < oy1);
    assign in_inner = (px >= ix0) && (px < ix1) && (ln >= iy0) && (ln < iy1);
    assign top_left = in_inner && (px == ix0) && (ln == iy0);

    // transitions: ENTER_FRAME, ENTER_PICTURE, ENTER_DIRECT, LEAVE_PICTURE,
    // LEAVE_FRAME, LEAVE_DIRECT, HOLD -- all follow the region of the counters
    always_comb begin
        if (in_inner) begin
            nxt = RG_INSET;
        end else if (in_outer) begin
            nxt = RG_BORDER;
        end else begin
            nxt = RG_OUTSIDE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RG_OUTSIDE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        sel        = 1'b0;
        frame_px   = 1'b0;
        frame_luma = '0;
        frame_hue  = '0;
        rd_en      = 1'b0;
        unique case (state)
            RG_OUTSIDE: begin
            end
            RG_BORDER: begin
                sel        = 1'b1;
                frame_px   = 1'b1;
                frame_luma = luma_q;
                frame_hue  = hue_q;
            end
            RG_INSET: begin
                sel   = 1'b1;
                rd_en = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // read address: zero at top-left, one step per active inset pixel
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            rd_addr <= '0;
        end else if (nxt == RG_INSET) begin
            rd_addr <= top_left ? '0 : cnt;
            cnt     <= top_left ? ADDR_W'(1) : cnt + ADDR_W'(1);
        end
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |->
        ((rd_addr == $past(rd_addr) + ADDR_W'(1)) || (rd_addr == '0))); // R9
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> $stable(rd_addr));                                    // R9

endmodule

// File: rtl/pip_inset_overlay.sv
module pip_inset_overlay
    import pip_ovl_pkg::*;
#(
    parameter int PIX_W     = 11,
    parameter int LINE_W    = 10,
    parameter int H_MARGIN  = 16,
    parameter int V_MARGIN  = 8,
    parameter int BH_NARROW = 2,
    parameter int BH_WIDE   = 4,
    parameter int BV_NARROW = 1,
    parameter int BV_WIDE   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hsync,
    input  logic                          vsync,
    input  logic                          cfg_quarter,
    input  logic [1:0]                    cfg_corner,
    input  logic                          cfg_frame_on,
    input  logic                          cfg_frame_wide,
    input  logic [3:0]                    cfg_frame_luma,
    input  logic [1:0]                    cfg_frame_hue,
    output logic                          sel,
    output logic                          frame_px,
    output logic [3:0]                    frame_luma,
    output logic [1:0]                    frame_hue,
    output logic                          rd_en,
    output logic [PIX_W+LINE_W-4:0]       rd_addr
);

    localparam int ADDR_W = PIX_W + LINE_W - 3;

    logic              hs_rise, vs_rise;
    logic [PIX_W-1:0]  px;
    logic [LINE_W-1:0] ln;
    ovl_cfg_t          cfg_in;
    logic [LUMA_W-1:0] luma_q;
    logic [HUE_W-1:0]  hue_q;
    logic [PIX_W-1:0]  ox0, ox1, ix0, ix1;
    logic [LINE_W-1:0] oy0, oy1, iy0, iy1;

    assign cfg_in = '{quarter:    cfg_quarter,
                      corner:     cfg_corner,
                      frame_on:   cfg_frame_on,
                      frame_wide: cfg_frame_wide,
                      luma:       cfg_frame_luma,
                      hue:        cfg_frame_hue};

    pip_ovl_sync #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .hs(hsync), .vs(vsync),
        .hs_rise(hs_rise), .vs_rise(vs_rise), .px(px), .ln(ln)
    );

    pip_ovl_geom #(
        .PIX_W(PIX_W), .LINE_W(LINE_W), .H_MARGIN(H_MARGIN), .V_MARGIN(V_MARGIN),
        .BH_NARROW(BH_NARROW), .BH_WIDE(BH_WIDE),
        .BV_NARROW(BV_NARROW), .BV_WIDE(BV_WIDE)
    ) u_geom (
        .clk(clk), .rst_n(rst_n), .vs_rise(vs_rise), .px(px), .ln(ln),
        .cfg_in(cfg_in), .luma_q(luma_q), .hue_q(hue_q),
        .ox0(ox0), .ox1(ox1), .ix0(ix0), .ix1(ix1),
        .oy0(oy0), .oy1(oy1), .iy0(iy0), .iy1(iy1)
    );

    pip_ovl_fsm #(.PIX_W(PIX_W), .LINE_W(LINE_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .px(px), .ln(ln),
        .ox0(ox0), .ox1(ox1), .ix0(ix0), .ix1(ix1),
        .oy0(oy0), .oy1(oy1), .iy0(iy0), .iy1(iy1),
        .luma_q(luma_q), .hue_q(hue_q),
        .sel(sel), .frame_px(frame_px), .frame_luma(frame_luma),
        .frame_hue(frame_hue), .rd_en(rd_en), .rd_addr(rd_addr)
    );

    AST_FRAME_IN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        frame_px |-> sel);                                           // R5
    AST_LUMA_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_px |-> ((frame_luma == '0) && (frame_hue == '0)));    // R4

endmodule

// File: tb/sim_pip_inset_overlay.sv
module sim_pip_inset_overlay;

    localparam int L  = 64;
    localparam int NF = 33;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync = 1'b0, vsync = 1'b0;
    logic cfg_quarter = 1'b0;
    logic [1:0] cfg_corner = '0;
    logic cfg_frame_on = 1'b0, cfg_frame_wide = 1'b0;
    logic [3:0] cfg_frame_luma = '0;
    logic [1:0] cfg_frame_hue = '0;
    logic sel, frame_px, rd_en;
    logic [3:0] frame_luma;
    logic [1:0] frame_hue;
    logic [17:0] rd_addr;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pip_inset_overlay u0 (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .cfg_quarter(cfg_quarter), .cfg_corner(cfg_corner),
        .cfg_frame_on(cfg_frame_on), .cfg_frame_wide(cfg_frame_wide),
        .cfg_frame_luma(cfg_frame_luma), .cfg_frame_hue(cfg_frame_hue),
        .sel(sel), .frame_px(frame_px), .frame_luma(frame_luma),
        .frame_hue(frame_hue), .rd_en(rd_en), .rd_addr(rd_addr)
    );

    task automatic check(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // expected-value pipe: stage 1 = last driven cycle, stage 2 = the one before
    bit p1_v, p2_v;
    int p1_sel, p1_brd, p1_luma, p1_hue, p1_rd, p1_addr;
    int p2_sel, p2_brd, p2_luma, p2_hue, p2_rd, p2_addr;

    task automatic check_pipe();
        if (p2_v) begin
            check("R5 R1 R2 sel", sel, p2_sel);
            check("R3 frame_px", frame_px, p2_brd);
            check("R4 frame_luma", frame_luma, p2_luma);
            check("R4 frame_hue", frame_hue, p2_hue);
            check("R9 rd_en", rd_en, p2_rd);
            if (p2_rd != 0) check("R9 rd_addr", rd_addr, p2_addr);
        end
        p2_v = p1_v; p2_sel = p1_sel; p2_brd = p1_brd; p2_luma = p1_luma;
        p2_hue = p1_hue; p2_rd = p1_rd; p2_addr = p1_addr;
    endtask

    initial begin
        int prev_nl;
        int q, crn, fon, fwd, lum, hue;
        int w, h, bh, bv, ox0, oy0, ix0, iy0;
        // R10: outputs idle in reset
        repeat (3) @(negedge clk);
        check("R10 sel", sel, 0);
        check("R10 rd_en", rd_en, 0);
        check("R10 frame_px", frame_px, 0);
        check("R10 frame_luma", frame_luma, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 sel after reset", sel, 0);
        check("R10 rd_addr after reset", rd_addr, 0);
        p1_v = 0; p2_v = 0;
        prev_nl = 40;
        for (int f = 0; f < NF; f++) begin
            int nl = (f % 2 == 1) ? 34 : 40;
            int i = (f == 0) ? 0 : f - 1;
            q = i & 1; crn = (i >> 1) & 3; fon = (i >> 3) & 1; fwd = (i >> 4) & 1;
            lum = (i & 15) ^ 5; hue = i & 3;
            // R1, R2, R3, R7: geometry from previous field's line count
            w  = (q != 0) ? L / 4 : L / 3;
            h  = (q != 0) ? prev_nl / 4 : prev_nl / 3;
            bh = (fon != 0) ? ((fwd != 0) ? 4 : 2) : 0;
            bv = (fon != 0) ? ((fwd != 0) ? 2 : 1) : 0;
            ox0 = ((crn & 1) != 0) ? L - 16 - (w + 2 * bh) : 16;
            oy0 = ((crn & 2) != 0) ? prev_nl - 8 - (h + 2 * bv) : 8;
            ix0 = ox0 + bh; iy0 = oy0 + bv;
            for (int y = 0; y < nl; y++) begin
                for (int x = 0; x < L; x++) begin
                    bit inner, outer;
                    @(negedge clk);
                    check_pipe();
                    hsync = (x == 0);
                    vsync = (x == 0) && (y == 0);
                    if (x == 0 && y == 0) begin
                        cfg_quarter = q[0]; cfg_corner = crn[1:0];
                        cfg_frame_on = fon[0]; cfg_frame_wide = fwd[0];
                        cfg_frame_luma = lum[3:0]; cfg_frame_hue = hue[1:0];
                    end else if (x == 0 && y == nl / 2) begin
                        // R8: mid-field write must not reach the outputs
                        cfg_quarter = ~cfg_quarter; cfg_corner = ~cfg_corner;
                        cfg_frame_on = ~cfg_frame_on; cfg_frame_wide = ~cfg_frame_wide;
                        cfg_frame_luma = ~cfg_frame_luma; cfg_frame_hue = ~cfg_frame_hue;
                    end
                    inner = (x >= ix0) && (x < ix0 + w) && (y >= iy0) && (y < iy0 + h);
                    outer = (x >= ox0) && (x < ox0 + w + 2 * bh) &&
                            (y >= oy0) && (y < oy0 + h + 2 * bv);
                    p1_v    = (f >= 1);
                    p1_sel  = outer ? 1 : 0;
                    p1_brd  = (outer && !inner) ? 1 : 0;
                    p1_luma = (outer && !inner) ? lum : 0;
                    p1_hue  = (outer && !inner) ? hue : 0;
                    p1_rd   = inner ? 1 : 0;
                    p1_addr = (y - iy0) * w + (x - ix0);
                end
            end
            prev_nl = nl;
        end
        @(negedge clk); check_pipe();
        @(negedge clk); check_pipe();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule